// File: doc/BRIEF.md
# Rotate, Mask and Shift Datapath

This block is the shared 64-bit bit-manipulation datapath of an integer execution pipeline. It holds a single left-rotator, a begin/end mask generator and a merge stage. Together they carry out these operations:

- rotate-then-mask, in both the 32-bit and 64-bit forms;
- mask-insert into a second operand;
- logical shifts left and right;
- arithmetic shifts right, which also give a carry flag;
- a left shift of a sign-extended low word.

The block is purely combinational. Six control flags pick the operation. The mask bounds come straight from the instruction word. The surrounding pipeline decodes the opcode into the flags. For the plain rotate-and-mask forms it supplies a zero merge operand, and for the insert forms it supplies the old destination value.

Mask bounds use most-significant-first numbering: a bound value k names result bit 63-k. A mask from begin b to end e covers every position k with b <= k <= e. When b > e, the mask instead covers k >= b together with k <= e, so it wraps around.

Top module: `rms_unit`

## Requirements
- R1: With word_mode_i=1 and clr_hi_i=clr_lo_i=1, the result is ROTL64({rs[31:0],rs[31:0]}, shamt[4:0]) under the mask from 32+insn[10:6] to 32+insn[5:1]. shamt[6:5] have no effect.
- R2: When the mask begin exceeds the mask end, in the 32-bit rotate form or in the 64-bit both-clear form, the mask wraps around as defined above.
- R3: In every rotate form (clr_hi_i or clr_lo_i set), result bits outside the mask are copied from ra_i. With ra_i=0 this yields the plain, non-insert forms.
- R4: With word_mode_i=0, clr_hi_i=1 and clr_lo_i=0, the result is ROTL64(rs, shamt[5:0]) under the mask from {insn[5],insn[10:6]} to 63.
- R5: With word_mode_i=0, clr_hi_i=0 and clr_lo_i=1, the result is ROTL64(rs, shamt[5:0]) under the mask from 0 to {insn[5],insn[10:6]}.
- R6: With word_mode_i=0 and both clear flags set, the result is ROTL64(rs, shamt[5:0]) under the mask from {insn[5],insn[10:6]} to 63-shamt[5:0].
- R7: With both clear flags and shr_i at 0, the block shifts left logically by the full 7-bit amount. In word mode it gives {32'b0, (rs[31:0]<<n)[31:0]}, and it gives 0 for n>=32. In 64-bit mode it gives rs<<n, and 0 for n>=64.
- R8: With shr_i=1 and arith_i=0 (clear flags at 0), the block shifts right logically. In word mode it gives zero-extended rs[31:0]>>n, and 0 for n>=32. In 64-bit mode it gives rs>>n, and 0 for n>=64.
- R9: With shr_i=1 and arith_i=1, the block shifts right arithmetically. The word form sign-extends its 32-bit result into all 64 bits. An amount of 32 or more (word) or 64 or more (64-bit) gives all copies of the sign bit (rs[31] or rs[63]).
- R10: carry_o is 1 only for an arithmetic right shift whose source is negative and loses at least one 1 bit. Otherwise it is 0.
- R11: With word_mode_i=0, no clear flag, shr_i=0 and sext_word_i=1, the result is {{32{rs[31]}},rs[31:0]} shifted left by the 7-bit amount (0 for n>=64). sext_word_i has no effect in word mode.
- R12: ra_i has no effect on the result or carry of any shift operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_i | input | 64 | Source operand that is rotated or shifted |
| ra_i | input | 64 | Merge operand for bits outside the mask in rotate forms |
| shamt_i | input | 7 | Shift or rotate amount |
| insn_i | input | 32 | Instruction word; bits 10..1 hold the mask bounds |
| word_mode_i | input | 1 | 1 selects 32-bit operation |
| shr_i | input | 1 | 1 selects a right shift |
| arith_i | input | 1 | With shr_i, selects sign fill and carry |
| clr_hi_i | input | 1 | Mask begins at the instruction's begin field |
| clr_lo_i | input | 1 | Mask ends at the instruction's end field (or at 63-amount) |
| sext_word_i | input | 1 | Sign-extend low word of rs before a 64-bit left shift |
| res_o | output | 64 | Result |
| carry_o | output | 1 | Carry from arithmetic right shifts |

## Verification
The hardest case to reach is a carry decided by a single bit. Here a negative source loses exactly its lowest set bit, or loses nothing at all, so carry_o hinges on whether the shifted-out field sits one position inside or outside the rotated-away window. Random operands almost never reach that edge. The bench therefore builds sources whose lowest set bit sits exactly at the shift amount, or one place below it, and adds amounts around 31, 32, 63 and 64 to cover the out-of-range fill. Wrapping masks are forced by choosing a begin field above the end field, including the 64-bit case where the end comes from the shift amount.

// File: rtl/rms_pkg.sv
package rms_pkg;
    localparam int XLEN  = 64;
    localparam int HLEN  = XLEN / 2;
    localparam int SHW   = $clog2(XLEN);
    localparam int AMTW  = SHW + 1;
    localparam int POSW  = SHW + 1;
    localparam int IW    = 32;
    // instruction field placement (fixed by the instruction format)
    localparam int F_BEG_LSB = 6;
    localparam int F_END_LSB = 1;
    localparam int F_FLDW    = SHW - 1;
    localparam int F_EXT_BIT = 5;

    typedef enum logic [1:0] {
        OP_ROTMASK = 2'd0,
        OP_SHL     = 2'd1,
        OP_SHR     = 2'd2
    } op_e;

    typedef struct packed {
        op_e             op;
        logic            word;
        logic            arith;
        logic            kill;
        logic            use_sext;
        logic [SHW-1:0]  rot_amt;
        logic [POSW-1:0] m_begin;
        logic [POSW-1:0] m_end;
    } ctl_t;

    typedef struct packed {
        logic [XLEN-1:0] src;
        logic [XLEN-1:0] fill;
        logic            sign;
        logic            lost;
    } dp_t;
endpackage

// File: rtl/rms_decode.sv
module rms_decode
    import rms_pkg::*;
(
    input  logic [AMTW-1:0] shamt_i,
    input  logic [IW-1:0]   insn_i,
    input  logic            word_i,
    input  logic            shr_i,
    input  logic            arith_i,
    input  logic            clr_hi_i,
    input  logic            clr_lo_i,
    input  logic            sext_i,
    output ctl_t            ctl_o
);
    localparam logic [POSW-1:0] TOP  = POSW'(XLEN - 1);
    localparam logic [POSW-1:0] HALF = POSW'(HLEN);

    logic [SHW-1:0]  eff;
    logic [POSW-1:0] eff_w;
    logic [POSW-1:0] base;
    logic [POSW-1:0] fld_dw;
    logic [POSW-1:0] fld_beg_w;
    logic [POSW-1:0] fld_end_w;
    logic            over;
    ctl_t            ctl_d;
    logic            unused_insn;

    assign unused_insn = ^{insn_i[IW-1:F_BEG_LSB+F_FLDW], insn_i[0]};

    always_comb begin
        // effective count: 5 bits in word mode, 6 bits otherwise
        eff       = word_i ? {1'b0, shamt_i[SHW-2:0]} : shamt_i[SHW-1:0];
        eff_w     = {1'b0, eff};
        base      = word_i ? HALF : '0;
        fld_dw    = {1'b0, insn_i[F_EXT_BIT], insn_i[F_BEG_LSB +: F_FLDW]};
        fld_beg_w = HALF + POSW'(insn_i[F_BEG_LSB +: F_FLDW]);
        fld_end_w = HALF + POSW'(insn_i[F_END_LSB +: F_FLDW]);
        over      = shamt_i[AMTW-1] | (word_i & shamt_i[SHW-1]);

        ctl_d          = '0;
        ctl_d.word     = word_i;
        ctl_d.rot_amt  = eff;
        if (clr_hi_i || clr_lo_i) begin
            ctl_d.op      = OP_ROTMASK;
            ctl_d.m_begin = clr_hi_i ? (word_i ? fld_beg_w : fld_dw) : base;
            if (!clr_lo_i)
                ctl_d.m_end = TOP;
            else if (word_i)
                ctl_d.m_end = fld_end_w;
            else if (clr_hi_i)
                ctl_d.m_end = TOP - eff_w;
            else
                ctl_d.m_end = fld_dw;
        end else if (shr_i) begin
            ctl_d.op      = OP_SHR;
            ctl_d.arith   = arith_i;
            ctl_d.kill    = over;
            ctl_d.rot_amt = '0 - eff;
            ctl_d.m_begin = base + eff_w;
            ctl_d.m_end   = TOP;
        end else begin
            ctl_d.op       = OP_SHL;
            ctl_d.kill     = over;
            ctl_d.use_sext = sext_i & ~word_i;
            ctl_d.m_begin  = base;
            ctl_d.m_end    = TOP - eff_w;
        end
    end

    assign ctl_o = ctl_d;

    // shift masks never wrap and never leave the 64 positions
    always_comb begin
        p_shift_nowrap_r7: assert ((ctl_o.op == OP_ROTMASK) || ctl_o.kill ||
                                   (ctl_o.m_begin <= ctl_o.m_end && ctl_o.m_end <= TOP))
            else $error("shift mask bounds out of order");
    end
endmodule

// File: rtl/rms_rotl.sv
module rms_rotl
    import rms_pkg::*;
(
    input  logic [XLEN-1:0] src_i,
    input  logic [SHW-1:0]  amt_i,
    output logic [XLEN-1:0] rot_o
);
    logic [XLEN-1:0] stg [SHW+1];

    assign stg[0] = src_i;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stg[s+1] = amt_i[s] ? {stg[s][XLEN-1-D:0], stg[s][XLEN-1 -: D]}
                                   : stg[s];
    end

    assign rot_o = stg[SHW];
endmodule

// File: rtl/rms_mask.sv
module rms_mask
    import rms_pkg::*;
(
    input  logic [POSW-1:0] mb_i,
    input  logic [POSW-1:0] me_i,
    input  logic            kill_i,
    output logic [XLEN-1:0] mask_o
);
    logic wrap;
    assign wrap = mb_i > me_i;

    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        localparam logic [POSW-1:0] K = POSW'(XLEN - 1 - i);
        logic ge_b;
        logic le_e;
        assign ge_b      = K >= mb_i;
        assign le_e      = K <= me_i;
        assign mask_o[i] = ~kill_i & (wrap ? (ge_b | le_e) : (ge_b & le_e));
    end

    always_comb begin
        p_span_r2: assert (kill_i || wrap || me_i >= POSW'(XLEN) ||
                           $countones(mask_o) == int'(me_i) - int'(mb_i) + 1)
            else $error("linear mask span wrong");
        p_wrap_span_r2: assert (kill_i || !wrap || mb_i >= POSW'(XLEN) ||
                                $countones(mask_o) == XLEN - int'(mb_i) + int'(me_i) + 1)
            else $error("wrapped mask span wrong");
    end
endmodule

// File: rtl/rms_unit.sv
module rms_unit
    import rms_pkg::*;
(
    input  logic [XLEN-1:0] rs_i,
    input  logic [XLEN-1:0] ra_i,
    input  logic [AMTW-1:0] shamt_i,
    input  logic [IW-1:0]   insn_i,
    input  logic            word_mode_i,
    input  logic            shr_i,
    input  logic            arith_i,
    input  logic            clr_hi_i,
    input  logic            clr_lo_i,
    input  logic            sext_word_i,
    output logic [XLEN-1:0] res_o,
    output logic            carry_o
);
    ctl_t            ctl;
    dp_t             dp_d;
    logic [XLEN-1:0] rot;
    logic [XLEN-1:0] mask;

    rms_decode u_dec (
        .shamt_i  (shamt_i),
        .insn_i   (insn_i),
        .word_i   (word_mode_i),
        .shr_i    (shr_i),
        .arith_i  (arith_i),
        .clr_hi_i (clr_hi_i),
        .clr_lo_i (clr_lo_i),
        .sext_i   (sext_word_i),
        .ctl_o    (ctl)
    );

    // source preparation
    always_comb begin
        if (ctl.word)
            dp_d.src = {rs_i[HLEN-1:0], rs_i[HLEN-1:0]};
        else if (ctl.use_sext)
            dp_d.src = {{HLEN{rs_i[HLEN-1]}}, rs_i[HLEN-1:0]};
        else
            dp_d.src = rs_i;
    end

    rms_rotl u_rot (
        .src_i (dp_d.src),
        .amt_i (ctl.rot_amt),
        .rot_o (rot)
    );

    rms_mask u_msk (
        .mb_i   (ctl.m_begin),
        .me_i   (ctl.m_end),
        .kill_i (ctl.kill),
        .mask_o (mask)
    );

    // fill, carry and merge
    always_comb begin
        dp_d.sign = ctl.word ? rs_i[HLEN-1] : rs_i[XLEN-1];
        unique case (ctl.op)
            OP_ROTMASK: dp_d.fill = ra_i;
            OP_SHR:     dp_d.fill = (ctl.arith && dp_d.sign) ? '1 : '0;
            default:    dp_d.fill = '0;
        endcase
        if (ctl.kill)
            dp_d.lost = ctl.word ? |rs_i[HLEN-1:0] : |rs_i;
        else if (ctl.word)
            dp_d.lost = |(rot[HLEN-1:0] & ~mask[HLEN-1:0]);
        else
            dp_d.lost = |(rot & ~mask);
        res_o   = (rot & mask) | (dp_d.fill & ~mask);
        carry_o = (ctl.op == OP_SHR) & ctl.arith & dp_d.sign & dp_d.lost;
    end

    always_comb begin
        p_in_mask_r1: assert ((res_o & mask) == (rot & mask))
            else $error("masked bits differ from rotator");
        p_word_dup_r1: assert (!ctl.word || rot[XLEN-1:HLEN] == rot[HLEN-1:0])
            else $error("word rotate lost its period");
        p_merge_ra_r3: assert (ctl.op != OP_ROTMASK || (res_o & ~mask) == (ra_i & ~mask))
            else $error("insert bits differ from ra");
        p_shift_zero_r12: assert (ctl.op == OP_ROTMASK || (ctl.op == OP_SHR && ctl.arith) ||
                                  (res_o & ~mask) == '0)
            else $error("logical shift fill not zero");
        p_over_sign_r9: assert (!(ctl.op == OP_SHR && ctl.arith && ctl.kill) ||
                                res_o == {XLEN{dp_d.sign}})
            else $error("oversized arithmetic shift not all sign");
        p_carry_neg_r10: assert (!carry_o || (arith_i && shr_i && dp_d.sign))
            else $error("carry without negative arithmetic shift");
    end
endmodule

// File: tb/sim_rms_unit.sv
module sim_rms_unit;
    logic        clk = 1'b0;
    always #4 clk = ~clk;

    logic [63:0] rs, ra, res;
    logic [6:0]  sh;
    logic [31:0] insn;
    logic        w, sr, ar, cl, cr, sx, ca;
    int          nvec = 0;
    int          nbad = 0;
    bit          done = 1'b0;

    rms_unit u0 (
        .rs_i(rs), .ra_i(ra), .shamt_i(sh), .insn_i(insn),
        .word_mode_i(w), .shr_i(sr), .arith_i(ar),
        .clr_hi_i(cl), .clr_lo_i(cr), .sext_word_i(sx),
        .res_o(res), .carry_o(ca)
    );

    // flag order {word, shr, arith, clr_hi, clr_lo, sext}
    localparam logic [5:0] F_RLW  = 6'b100110;
    localparam logic [5:0] F_DCL  = 6'b000100;
    localparam logic [5:0] F_DCR  = 6'b000010;
    localparam logic [5:0] F_DC   = 6'b000110;
    localparam logic [5:0] F_SLW  = 6'b100000;
    localparam logic [5:0] F_SLD  = 6'b000000;
    localparam logic [5:0] F_SRW  = 6'b110000;
    localparam logic [5:0] F_SRD  = 6'b010000;
    localparam logic [5:0] F_SRAW = 6'b111000;
    localparam logic [5:0] F_SRAD = 6'b011000;
    localparam logic [5:0] F_EXS  = 6'b000001;

    function automatic logic [63:0] bmask(int b, int e);
        logic [63:0] m;
        m = '0;
        for (int k = 0; k < 64; k++)
            m[63-k] = (b <= e) ? (k >= b && k <= e) : (k >= b || k <= e);
        return m;
    endfunction

    function automatic logic [63:0] rol(logic [63:0] x, int n);
        logic [127:0] t;
        t = {x, x} << (n % 64);
        return t[127:64];
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    task automatic drive(logic [63:0] a_rs, logic [63:0] a_ra, logic [6:0] a_sh,
                         logic [31:0] a_insn, logic [5:0] fl);
        @(negedge clk);
        rs = a_rs; ra = a_ra; sh = a_sh; insn = a_insn;
        {w, sr, ar, cl, cr, sx} = fl;
        #2;
    endtask

    task automatic chk(string tag, logic [63:0] er, logic ec);
        nvec++;
        if (res !== er || ca !== ec) begin
            nbad++;
            $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                     tag, res, ca, er, ec);
        end
    endtask

    // ---------------- reference pieces ----------------
    function automatic logic [63:0] ref_shl(logic [63:0] x, int n, bit word);
        logic [31:0] lw;
        if (word) begin
            lw = x[31:0] << (n % 32);
            return (n >= 32) ? 64'h0 : {32'h0, lw};
        end
        return (n >= 64) ? 64'h0 : (x << n);
    endfunction

    function automatic logic [63:0] ref_shr(logic [63:0] x, int n, bit word);
        logic [31:0] lw;
        if (word) begin
            lw = x[31:0] >> (n % 32);
            return (n >= 32) ? 64'h0 : {32'h0, lw};
        end
        return (n >= 64) ? 64'h0 : (x >> n);
    endfunction

    function automatic logic [64:0] ref_sra(logic [63:0] x, int n, bit word);
        logic signed [31:0] sw;
        logic signed [63:0] sd;
        logic [31:0] lost_w;
        logic [63:0] lost_d;
        logic c;
        if (word) begin
            if (n >= 32) return {x[31] & (|x[31:0]), {64{x[31]}}};
            sw = x[31:0];
            sw = sw >>> n;
            lost_w = x[31:0] & ((32'h1 << n) - 32'h1);
            c = x[31] & (|lost_w);
            return {c, {32{sw[31]}}, sw};
        end
        if (n >= 64) return {x[63] & (|x), {64{x[63]}}};
        sd = x;
        sd = sd >>> n;
        lost_d = x & ((64'h1 << n) - 64'h1);
        c = x[63] & (|lost_d);
        return {c, sd};
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_idle();
        drive(64'h0, 64'h0, 7'd0, 32'h0, F_SLD);
        chk("R7 all-zero idle", 64'h0, 1'b0);
    endtask

    task automatic t_word_rot();
        for (int i = 0; i < 300; i++) begin
            logic [63:0] a, b, m, e;
            logic [31:0] in;
            logic [6:0]  s;
            a = rnd64(); b = (i % 2 == 0) ? 64'h0 : rnd64();
            in = $urandom(); s = 7'($urandom());
            drive(a, b, s, in, F_RLW);
            m = bmask(32 + int'(in[10:6]), 32 + int'(in[5:1]));
            e = (rol({a[31:0], a[31:0]}, int'(s[4:0])) & m) | (b & ~m);
            chk((i % 2 == 0) ? "R1 word rotate-mask" : "R3 word insert", e, 1'b0);
        end
        // forced wrap: begin 20, end 5
        begin
            logic [63:0] a, m, e;
            a = 64'h0123_4567_89AB_CDEF;
            drive(a, 64'h0, 7'd9, {21'h0, 5'd20, 5'd5, 1'b0}, F_RLW);
            m = bmask(52, 37);
            e = rol({a[31:0], a[31:0]}, 9) & m;
            chk("R2 word wrap mask", e, 1'b0);
        end
    endtask

    task automatic t_dw_clear_hi();
        for (int i = 0; i < 250; i++) begin
            logic [63:0] a, b, m, e;
            logic [31:0] in;
            logic [6:0]  s;
            a = rnd64(); b = (i % 2 == 0) ? 64'h0 : rnd64();
            in = $urandom(); s = 7'($urandom());
            drive(a, b, s, in, F_DCL);
            m = bmask(int'({in[5], in[10:6]}), 63);
            e = (rol(a, int'(s[5:0])) & m) | (b & ~m);
            chk("R4 dword clear-left", e, 1'b0);
        end
    endtask

    task automatic t_dw_clear_lo();
        for (int i = 0; i < 250; i++) begin
            logic [63:0] a, b, m, e;
            logic [31:0] in;
            logic [6:0]  s;
            a = rnd64(); b = (i % 2 == 0) ? 64'h0 : rnd64();
            in = $urandom(); s = 7'($urandom());
            drive(a, b, s, in, F_DCR);
            m = bmask(0, int'({in[5], in[10:6]}));
            e = (rol(a, int'(s[5:0])) & m) | (b & ~m);
            chk("R5 dword clear-right", e, 1'b0);
        end
    endtask

    task automatic t_dw_clear_both();
        for (int i = 0; i < 300; i++) begin
            logic [63:0] a, b, m, e;
            logic [31:0] in;
            logic [6:0]  s;
            int mb, me;
            a = rnd64(); b = (i % 2 == 0) ? 64'h0 : rnd64();
            in = $urandom(); s = {1'b0, 6'($urandom())};
            drive(a, b, s, in, F_DC);
            mb = int'({in[5], in[10:6]});
            me = 63 - int'(s[5:0]);
            m = bmask(mb, me);
            e = (rol(a, int'(s[5:0])) & m) | (b & ~m);
            chk((mb > me) ? "R2 dword wrap mask" : "R6 dword clear-both", e, 1'b0);
        end
        // sext_word set in a rotate form must not matter
        begin
            logic [63:0] a, m, e;
            a = 64'h0000_0000_8000_0001;
            drive(a, 64'h0, 7'd4, {21'h0, 5'd2, 5'd0, 1'b0}, F_DC | 6'b000001);
            m = bmask(2, 59);
            e = rol(a, 4) & m;
            chk("R11 sext ignored in rotate", e, 1'b0);
        end
    endtask

    task automatic t_shift_left();
        int bnd[8] = '{0, 1, 31, 32, 33, 63, 64, 127};
        for (int i = 0; i < 216; i++) begin
            logic [63:0] a, b;
            logic [6:0]  s;
            bit word;
            a = rnd64(); b = rnd64(); word = (i % 2 == 1);
            s = (i < 16) ? 7'(bnd[i / 2]) : 7'($urandom());
            drive(a, b, s, 32'($urandom()), word ? F_SLW : F_SLD);
            chk("R7 R12 shift left", ref_shl(a, int'(s), word), 1'b0);
        end
    endtask

    task automatic t_shift_right();
        int bnd[8] = '{0, 1, 31, 32, 33, 63, 64, 127};
        for (int i = 0; i < 216; i++) begin
            logic [63:0] a, b;
            logic [6:0]  s;
            bit word;
            a = rnd64() | 64'h8000_0000_8000_0000; b = rnd64(); word = (i % 2 == 1);
            s = (i < 16) ? 7'(bnd[i / 2]) : 7'($urandom());
            drive(a, b, s, 32'($urandom()), word ? F_SRW : F_SRD);
            chk("R8 R10 R12 logical right", ref_shr(a, int'(s), word), 1'b0);
        end
    endtask

    task automatic t_shift_arith();
        int bnd[8] = '{0, 1, 31, 32, 33, 63, 64, 127};
        for (int i = 0; i < 300; i++) begin
            logic [63:0] a, b;
            logic [64:0] e;
            logic [6:0]  s;
            bit word;
            a = rnd64(); b = rnd64(); word = (i % 2 == 1);
            s = (i < 16) ? 7'(bnd[i / 2]) : 7'($urandom());
            drive(a, b, s, 32'($urandom()), word ? F_SRAW : F_SRAD);
            e = ref_sra(a, int'(s), word);
            chk("R9 R12 arithmetic right", e[63:0], e[64]);
        end
        // single-bit carry edges: lowest set bit exactly lost, or just kept
        for (int n = 1; n < 32; n++) begin
            logic [63:0] a;
            logic [64:0] e;
            a = {32'h0, 32'h8000_0000 | (32'h1 << (n - 1))};
            drive(a, 64'h0, 7'(n), 32'h0, F_SRAW);
            e = ref_sra(a, n, 1'b1);
            chk("R10 word carry lowest bit lost", e[63:0], e[64]);
            a = {32'h0, 32'h8000_0000 | (32'h1 << n)};
            drive(a, 64'h0, 7'(n), 32'h0, F_SRAW);
            e = ref_sra(a, n, 1'b1);
            chk("R10 word carry lowest bit kept", e[63:0], e[64]);
        end
        for (int n = 1; n < 64; n++) begin
            logic [63:0] a;
            logic [64:0] e;
            a = 64'h8000_0000_0000_0000 | (64'h1 << (n - 1));
            drive(a, 64'h0, 7'(n), 32'h0, F_SRAD);
            e = ref_sra(a, n, 1'b0);
            chk("R10 dword carry edge", e[63:0], e[64]);
        end
        // positive source never carries
        drive(64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 7'd70, 32'h0, F_SRAD);
        chk("R10 positive no carry", 64'h0, 1'b0);
    endtask

    task automatic t_sext_shift();
        for (int i = 0; i < 200; i++) begin
            logic [63:0] a, v;
            logic [6:0]  s;
            a = rnd64(); s = (i < 4) ? 7'(62 + i) : 7'($urandom());
            v = {{32{a[31]}}, a[31:0]};
            drive(a, rnd64(), s, 32'h0, F_EXS);
            chk("R11 sign-extend then shift", (s >= 7'd64) ? 64'h0 : (v << s), 1'b0);
        end
        for (int i = 0; i < 50; i++) begin
            logic [63:0] a;
            logic [6:0]  s;
            a = rnd64() | 64'h8000_0000; s = 7'($urandom());
            drive(a, 64'h0, s, 32'h0, F_SLW | 6'b000001);
            chk("R11 sext ignored in word mode", ref_shl(a, int'(s), 1'b1), 1'b0);
        end
    endtask

    initial begin
        rs = '0; ra = '0; sh = '0; insn = '0;
        {w, sr, ar, cl, cr, sx} = '0;
        t_idle();
        t_word_rot();
        t_dw_clear_hi();
        t_dw_clear_lo();
        t_dw_clear_both();
        t_shift_left();
        t_shift_right();
        t_shift_arith();
        t_sext_shift();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule